// File: doc/BRIEF.md
# Platform Sleep-State Power Sequencer

This block runs from standby power and keeps track of the global power state of the platform. The states are working (S0), the light and memory-retaining sleep states (S1, S3), and the two soft-off states (S4, S5). Software moves the platform out of S0 with a single register write. That write carries a sleep kind and a go bit. The block then drives four active-low controls: a processor stop-clock, a memory-retain sleep line, a full-off sleep line and the main-supply enable.

While the platform sleeps, any of five synchronized wake request lines can return it to S0: network, modem ring, keyboard, USB and alarm. A debounced power button can do the same. Each of these six sources counts only when its enable bit is set. A sticky status vector records which source caused the last resume, and software clears it by writing ones.

A long hold of the button forces soft-off regardless of the register. A short press in S0 also requests soft-off. When standby power first returns, a restore policy chooses the first state: stay off, come on, or come on for a set number of cycles to arm the wake logic and then drop to S5.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is held and during the start-up cycle after it, stop_clk_n, sleep_mem_n and sleep_off_n are all low, main_on_n is high, sleep_state reads 5 and wake_stat reads 0.
- R2: In S0, a write with reg_wr=1 and sleep_go=1 enters the state named by sleep_kind: 1 gives S1, 3 gives S3, 4 gives S4 and 5 gives S5. The outputs change at the clock edge that samples the write. sleep_state reports 0, 1, 3, 4 or 5 for the state (the arm phase reports 0).
- R3: The outputs decode from the state as follows. S0 has all four outputs high except main_on_n. S1 drives only stop_clk_n low. S3 drives stop_clk_n and sleep_mem_n low. S4 and S5 drive stop_clk_n, sleep_mem_n and sleep_off_n low.
- R4: These writes have no effect, and the block stays in its current state: sleep_kind of 0, 2, 6 or 7; sleep_go=0; or any write while the platform is not in S0.
- R5: main_on_n is the NAND of sleep_mem_n and an internal power-enable term that is set once start-up ends. It is therefore low only in S0, S1 and the arm phase.
- R6: In S1, S3, S4 or S5, a high wake_req[i] whose wake_en[i] is set returns the block to S0. The bit order is 0 network, 1 ring, 2 keyboard, 3 USB, 4 alarm. The request reaches the state on the third clock edge after it rises, because of a two-flop synchronizer. A disabled source has no effect.
- R7: After synchronization and a debounce of DEB_MS ticks, a button press (pbtn_n low) wakes the block from any sleep state if wake_en[5] is set. If a press starts in S0 and is released before the override, the block goes to S5 on the release. A release that follows a press that woke the platform is ignored.
- R8: If the debounced button stays pressed for OVR_MS ticks of TICK_DIV cycles each, the block goes to S5 from any state. This happens whatever the enables and the register say.
- R9: After reset, restore_mode 1 enters S0. Mode 0 or 3 enters S5. Mode 2 enters an arm phase with S0 outputs that lasts arm_len+1 cycles and then goes to S5.
- R10: On a resume, wake_stat bit i (the same bit order as wake_en) is set for each enabled source that caused it. The bits hold until a stat_clr_wr with a 1 in that bit of stat_clr_mask clears them. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, standby power good |
| reg_wr | input | 1 | One-cycle sleep-control register write strobe |
| sleep_go | input | 1 | Go bit of the write |
| sleep_kind | input | 3 | Requested sleep kind |
| stat_clr_wr | input | 1 | Status clear strobe |
| stat_clr_mask | input | 6 | Write-one-to-clear mask for wake_stat |
| wake_en | input | 6 | Per-source wake enables, bit 5 the button |
| wake_req | input | 5 | Asynchronous wake requests |
| pbtn_n | input | 1 | Raw power button, low when pressed |
| restore_mode | input | 2 | Policy after standby power returns |
| arm_len | input | ARM_W | Arm phase length minus one, in cycles |
| stop_clk_n | output | 1 | Processor stop-clock, active low |
| sleep_mem_n | output | 1 | Memory-retain sleep line, active low |
| sleep_off_n | output | 1 | Full-off sleep line, active low |
| main_on_n | output | 1 | Main supply enable, active low |
| sleep_state | output | 3 | Current state code |
| wake_stat | output | 6 | Sticky wake-cause status |

## Verification
A register write shows on the outputs at the negative edge that follows its sampling edge, and the bench checks it there. A wake request is checked twice, at the second negative edge after it is raised (still asleep) and at the third (awake). A late enable on a request that is already synchronized takes effect after one edge. Button effects depend on the tick count, so the bench samples them at points that lie well inside their windows: mid-press, after release plus settling time, and after the override span. The restore checks count the two reset-synchronizer flops, the start-up cycle and the arm_len+1 arm cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NWAKE = 5;
  localparam int NSRC  = NWAKE + 1;

  typedef enum logic [2:0] {
    ST_BOOT, ST_S0, ST_S1, ST_S3, ST_S4, ST_S5, ST_ARM
  } pst_e;

  localparam logic [1:0] RM_OFF = 2'd0;
  localparam logic [1:0] RM_ON  = 2'd1;
  localparam logic [1:0] RM_ARM = 2'd2;

  function automatic logic is_asleep(pst_e s);
    return (s == ST_S1) || (s == ST_S3) || (s == ST_S4) || (s == ST_S5);
  endfunction
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] RVAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RVAL;
      q    <= RVAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pwrseq_button.sv
module pwrseq_button #(
  parameter int TICK_DIV = 50000,
  parameter int DEB_MS   = 16,
  parameter int OVR_MS   = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pressed,
  output logic press_p,
  output logic rel_p,
  output logic ovr_p
);
  localparam int TW = $clog2(TICK_DIV + 1);
  localparam int DW = $clog2(DEB_MS + 1);
  localparam int HW = $clog2(OVR_MS + 1);

  logic [TW-1:0] tick_q, tick_d;
  logic [DW-1:0] deb_q, deb_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          stable_q, stable_d;
  logic          tick;

  always_comb begin
    tick   = (tick_q == TW'(TICK_DIV - 1));
    tick_d = tick ? '0 : tick_q + 1'b1;
    deb_d    = deb_q;
    stable_d = stable_q;
    if (pressed == stable_q) begin
      deb_d = '0;
    end else if (tick) begin
      if (deb_q == DW'(DEB_MS - 1)) begin
        stable_d = pressed;
        deb_d    = '0;
      end else begin
        deb_d = deb_q + 1'b1;
      end
    end
    hold_d = hold_q;
    if (!stable_q)                             hold_d = '0;
    else if (tick && hold_q != HW'(OVR_MS))    hold_d = hold_q + 1'b1;
    press_p = !stable_q && stable_d;
    rel_p   = stable_q && !stable_d;
    ovr_p   = stable_q && tick && (hold_q == HW'(OVR_MS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= '0;
      deb_q    <= '0;
      hold_q   <= '0;
      stable_q <= 1'b0;
    end else begin
      tick_q   <= tick_d;
      deb_q    <= deb_d;
      hold_q   <= hold_d;
      stable_q <= stable_d;
    end
  end
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int ARM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       restore_mode,
  input  logic [ARM_W-1:0] arm_len,
  input  logic             reg_wr,
  input  logic             sleep_go,
  input  logic [2:0]       sleep_kind,
  input  logic             stat_clr_wr,
  input  logic [NSRC-1:0]  stat_clr_mask,
  input  logic [NSRC-1:0]  wake_en,
  input  logic [NWAKE-1:0] wake_sync,
  input  logic             btn_press,
  input  logic             btn_rel,
  input  logic             btn_ovr,
  output pst_e             state_q,
  output logic             pwr_en_q,
  output logic [NSRC-1:0]  wake_stat
);
  pst_e             state_d;
  logic [ARM_W-1:0] arm_q, arm_d;
  logic             own_q, own_d;
  logic [NSRC-1:0]  hit, stat_set, stat_d;

  always_comb begin
    hit      = {btn_press & wake_en[NSRC-1], wake_sync & wake_en[NWAKE-1:0]};
    state_d  = state_q;
    arm_d    = arm_q;
    stat_set = '0;
    unique case (state_q)
      ST_BOOT: begin
        if (restore_mode == RM_ON) state_d = ST_S0;
        else if (restore_mode == RM_ARM) begin
          state_d = ST_ARM;
          arm_d   = arm_len;
        end else state_d = ST_S5;
      end
      ST_S0: begin
        if (btn_ovr)                  state_d = ST_S5;
        else if (btn_rel && own_q)    state_d = ST_S5;
        else if (reg_wr && sleep_go) begin
          unique case (sleep_kind)
            3'd1:    state_d = ST_S1;
            3'd3:    state_d = ST_S3;
            3'd4:    state_d = ST_S4;
            3'd5:    state_d = ST_S5;
            default: state_d = ST_S0;
          endcase
        end
      end
      ST_ARM: begin
        if (btn_ovr || arm_q == '0) state_d = ST_S5;
        else                        arm_d   = arm_q - 1'b1;
      end
      default: begin
        if (btn_ovr) state_d = ST_S5;
        else if (|hit) begin
          state_d  = ST_S0;
          stat_set = hit;
        end
      end
    endcase
    own_d  = (state_q == ST_S0) && (state_d == ST_S0) && (own_q || btn_press) && !btn_rel;
    stat_d = (wake_stat & ~(stat_clr_wr ? stat_clr_mask : '0)) | stat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_BOOT;
      arm_q     <= '0;
      own_q     <= 1'b0;
      pwr_en_q  <= 1'b0;
      wake_stat <= '0;
    end else begin
      state_q   <= state_d;
      arm_q     <= arm_d;
      own_q     <= own_d;
      pwr_en_q  <= 1'b1;
      wake_stat <= stat_d;
    end
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwrseq_pkg::*;
#(
  parameter int TICK_DIV = 50000,
  parameter int DEB_MS   = 16,
  parameter int OVR_MS   = 4000,
  parameter int ARM_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             sleep_go,
  input  logic [2:0]       sleep_kind,
  input  logic             stat_clr_wr,
  input  logic [5:0]       stat_clr_mask,
  input  logic [5:0]       wake_en,
  input  logic [4:0]       wake_req,
  input  logic             pbtn_n,
  input  logic [1:0]       restore_mode,
  input  logic [ARM_W-1:0] arm_len,
  output logic             stop_clk_n,
  output logic             sleep_mem_n,
  output logic             sleep_off_n,
  output logic             main_on_n,
  output logic [2:0]       sleep_state,
  output logic [5:0]       wake_stat
);
  logic [1:0]       rs_q;
  logic             rs_n;
  logic [NWAKE-1:0] wake_sync;
  logic             pb_sync;
  logic             btn_press, btn_rel, btn_ovr;
  pst_e             state_q;
  logic             pwr_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  pwrseq_sync #(.W(NWAKE), .RVAL('0)) u_wsync (
    .clk(clk), .rst_n(rs_n), .d(wake_req), .q(wake_sync));

  pwrseq_sync #(.W(1), .RVAL(1'b1)) u_psync (
    .clk(clk), .rst_n(rs_n), .d(pbtn_n), .q(pb_sync));

  pwrseq_button #(.TICK_DIV(TICK_DIV), .DEB_MS(DEB_MS), .OVR_MS(OVR_MS)) u_btn (
    .clk(clk), .rst_n(rs_n), .pressed(!pb_sync),
    .press_p(btn_press), .rel_p(btn_rel), .ovr_p(btn_ovr));

  pwrseq_fsm #(.ARM_W(ARM_W)) u_fsm (
    .clk(clk), .rst_n(rs_n), .restore_mode(restore_mode), .arm_len(arm_len),
    .reg_wr(reg_wr), .sleep_go(sleep_go), .sleep_kind(sleep_kind),
    .stat_clr_wr(stat_clr_wr), .stat_clr_mask(stat_clr_mask),
    .wake_en(wake_en), .wake_sync(wake_sync),
    .btn_press(btn_press), .btn_rel(btn_rel), .btn_ovr(btn_ovr),
    .state_q(state_q), .pwr_en_q(pwr_en_q), .wake_stat(wake_stat));

  always_comb begin
    stop_clk_n  = (state_q == ST_S0) || (state_q == ST_ARM);
    sleep_mem_n = stop_clk_n || (state_q == ST_S1);
    sleep_off_n = sleep_mem_n || (state_q == ST_S3);
    main_on_n   = !(sleep_mem_n && pwr_en_q);
    unique case (state_q)
      ST_S1:   sleep_state = 3'd1;
      ST_S3:   sleep_state = 3'd3;
      ST_S4:   sleep_state = 3'd4;
      ST_S0, ST_ARM: sleep_state = 3'd0;
      default: sleep_state = 3'd5;
    endcase
  end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwrseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input pst_e       state_q,
  input logic       reg_wr,
  input logic       sleep_go,
  input logic [2:0] sleep_kind,
  input logic       stop_clk_n,
  input logic       sleep_mem_n,
  input logic       sleep_off_n,
  input logic       main_on_n,
  input logic [5:0] wake_stat,
  input logic       stat_clr_wr,
  input logic [5:0] stat_clr_mask,
  input logic       btn_ovr,
  input logic       btn_rel,
  input logic [4:0] wake_sync,
  input logic [5:0] wake_en
);
  AST_OFF_HAS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_off_n |-> (!sleep_mem_n && !stop_clk_n)); // R3
  AST_MEM_HAS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_mem_n |-> !stop_clk_n); // R3
  AST_MAIN_ONLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !main_on_n |-> (sleep_mem_n && sleep_off_n)); // R5
  AST_KIND2_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_S0 && reg_wr && sleep_go && sleep_kind == 3'd2 && !btn_ovr && !btn_rel)
      |=> (stop_clk_n && sleep_mem_n)); // R4
  AST_OVR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    btn_ovr |=> !sleep_off_n); // R8
  AST_WAKE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (is_asleep(state_q) && !btn_ovr && (wake_sync & wake_en[4:0]) != 5'd0)
      |=> state_q == ST_S0); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(wake_stat) & ~($past(stat_clr_wr) ? $past(stat_clr_mask) : 6'd0))
               & ~wake_stat) == 6'd0)); // R10
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .reg_wr(reg_wr),
  .sleep_go(sleep_go), .sleep_kind(sleep_kind), .stop_clk_n(stop_clk_n),
  .sleep_mem_n(sleep_mem_n), .sleep_off_n(sleep_off_n), .main_on_n(main_on_n),
  .wake_stat(wake_stat), .stat_clr_wr(stat_clr_wr), .stat_clr_mask(stat_clr_mask),
  .btn_ovr(btn_ovr), .btn_rel(btn_rel), .wake_sync(wake_sync), .wake_en(wake_en));

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
  localparam int ARM_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, sleep_go, stat_clr_wr, pbtn_n;
  logic [2:0] sleep_kind;
  logic [5:0] stat_clr_mask, wake_en;
  logic [4:0] wake_req;
  logic [1:0] restore_mode;
  logic [ARM_W-1:0] arm_len;
  logic stop_clk_n, sleep_mem_n, sleep_off_n, main_on_n;
  logic [2:0] sleep_state;
  logic [5:0] wake_stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [5:0] stat_exp;

  always #10 clk = ~clk;

  pwr_state_ctrl #(.TICK_DIV(4), .DEB_MS(3), .OVR_MS(40), .ARM_W(ARM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .sleep_go(sleep_go),
    .sleep_kind(sleep_kind), .stat_clr_wr(stat_clr_wr), .stat_clr_mask(stat_clr_mask),
    .wake_en(wake_en), .wake_req(wake_req), .pbtn_n(pbtn_n),
    .restore_mode(restore_mode), .arm_len(arm_len),
    .stop_clk_n(stop_clk_n), .sleep_mem_n(sleep_mem_n), .sleep_off_n(sleep_off_n),
    .main_on_n(main_on_n), .sleep_state(sleep_state), .wake_stat(wake_stat));

  function automatic logic [3:0] exp_pins(input logic [2:0] code);
    case (code)
      3'd0:    return 4'b1110;
      3'd1:    return 4'b0110;
      3'd3:    return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_st(input string req, input logic [2:0] code);
    chk(req, {29'd0, sleep_state}, {29'd0, code});
    chk(req, {28'd0, stop_clk_n, sleep_mem_n, sleep_off_n, main_on_n}, {28'd0, exp_pins(code)});
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic go, input logic [2:0] kind);
    reg_wr = 1'b1; sleep_go = go; sleep_kind = kind;
    @(negedge clk);
    reg_wr = 1'b0; sleep_go = 1'b0;
  endtask

  task automatic clr(input logic [5:0] m);
    stat_clr_wr = 1'b1; stat_clr_mask = m;
    @(negedge clk);
    stat_clr_wr = 1'b0; stat_clr_mask = '0;
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n = 1'b0; restore_mode = mode;
    cyc(3);
    rst_n = 1'b1;
    stat_exp = '0;
  endtask

  function automatic logic [2:0] kind_pick(input int k);
    case (k)
      0: return 3'd1;
      1: return 3'd3;
      2: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_wr = 0; sleep_go = 0; sleep_kind = 0; stat_clr_wr = 0;
    stat_clr_mask = 0; wake_en = 0; wake_req = 0; pbtn_n = 1; restore_mode = 2'd1;
    arm_len = 8'd10; stat_exp = '0;
    cyc(3);
    chk_st("R1 reset", 3'd5);
    chk("R1 stat", {26'd0, wake_stat}, 32'd0);

    // restore on
    do_reset(2'd1);
    @(negedge clk); @(negedge clk);
    chk_st("R1 boot cycle", 3'd5);
    cyc(3);
    chk_st("R9 restore on", 3'd0);

    // ignored writes
    wr(1'b0, 3'd3); chk_st("R4 go=0", 3'd0);
    wr(1'b1, 3'd2); chk_st("R4 kind 2", 3'd0);
    wr(1'b1, 3'd0); chk_st("R4 kind 0", 3'd0);
    wr(1'b1, 3'd6); chk_st("R4 kind 6", 3'd0);
    wr(1'b1, 3'd7); chk_st("R4 kind 7", 3'd0);

    // entry and write in sleep
    wr(1'b1, 3'd3); chk_st("R2 R3 R5 enter S3", 3'd3);
    wr(1'b1, 3'd1); chk_st("R4 write while asleep", 3'd3);

    // wake latency
    wake_en = 6'h1F; wake_req = 5'b00010;
    cyc(2); chk_st("R6 not yet", 3'd3);
    cyc(1); chk_st("R6 wake ring", 3'd0);
    stat_exp = 6'h02;
    chk("R10 stat ring", {26'd0, wake_stat}, {26'd0, stat_exp});
    wake_req = 0; cyc(3);
    clr(6'h02); stat_exp = 0;
    chk("R10 w1c", {26'd0, wake_stat}, 32'd0);

    // random sleep/wake rounds
    for (int it = 0; it < 40; it++) begin
      logic [2:0] k;
      logic [4:0] en;
      int src;
      logic [5:0] m;
      k = kind_pick($urandom % 4);
      en = 5'($urandom);
      src = $urandom % 5;
      wake_en = {1'b0, en};
      wr(1'b1, k); chk_st("R2 R3 random entry", k);
      wake_req[src] = 1'b1;
      cyc(3);
      if (en[src]) begin
        chk_st("R6 enabled source wakes", 3'd0);
      end else begin
        chk_st("R6 disabled source ignored", k);
        wake_en[src] = 1'b1;
        cyc(1);
        chk_st("R6 late enable wakes", 3'd0);
      end
      stat_exp[src] = 1'b1;
      chk("R10 random stat", {26'd0, wake_stat}, {26'd0, stat_exp});
      wake_req = 0; cyc(3);
      if ($urandom % 2 == 1) begin
        m = 6'($urandom);
        clr(m); stat_exp = stat_exp & ~m;
        chk("R10 random clear", {26'd0, wake_stat}, {26'd0, stat_exp});
      end
    end
    clr(6'h3F); stat_exp = 0;

    // short press in S0 -> S5 on release
    wake_en = 6'h20;
    pbtn_n = 0; cyc(60);
    chk_st("R7 held short press still S0", 3'd0);
    pbtn_n = 1; cyc(40);
    chk_st("R7 short press release to S5", 3'd5);

    // button wake from S5, release ignored
    pbtn_n = 0; cyc(30);
    chk_st("R7 button wake", 3'd0);
    chk("R7 R10 button stat", {26'd0, wake_stat}, 32'h20);
    pbtn_n = 1; cyc(40);
    chk_st("R7 release after wake ignored", 3'd0);
    clr(6'h3F);

    // override from S3 with all wakes disabled
    wake_en = 0;
    wr(1'b1, 3'd3); chk_st("R2 enter S3", 3'd3);
    pbtn_n = 0; cyc(100);
    chk_st("R8 disabled button no wake", 3'd3);
    cyc(150);
    chk_st("R8 override from S3", 3'd5);
    pbtn_n = 1; cyc(40);

    // override from S0 while still held
    wake_en = 6'h01; wake_req = 5'b00001; cyc(3);
    chk_st("R6 lan wake", 3'd0);
    wake_req = 0; cyc(3);
    pbtn_n = 0; cyc(250);
    chk_st("R8 override from S0 while held", 3'd5);
    pbtn_n = 1; cyc(40);

    // restore off
    do_reset(2'd0); cyc(6);
    chk_st("R9 restore off", 3'd5);

    // restore arm
    arm_len = 8'd10;
    do_reset(2'd2);
    cyc(6);
    chk_st("R9 arm phase on", 3'd0);
    cyc(7);
    chk_st("R9 arm phase last cycle", 3'd0);
    cyc(2);
    chk_st("R9 arm then off", 3'd5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule